// File: doc/BRIEF.md
# Decade Rate Tick Generator

The block turns a fast reference clock (10 MHz in its default build) into a periodic single-cycle tick. A 3-bit rate code chooses the tick period: from 10 microseconds to 10 seconds, with each step ten times the one before. Inside there is a chain of modulo counters. The first counter divides the reference clock down to the shortest period, and each later counter divides the output of the one before it by ten. A selector forwards the terminal count of the chosen counter, and a register turns it into the tick.

A downstream event counter uses the tick as its count enable, and a control path drives the load strobe. A load captures the rate code presented with it and restarts every counter in the chain from zero. The first tick after a load therefore comes exactly one full period later, whatever phase the chain was in. Code zero stops the tick while the counters keep running. The captured code is driven back out for status readback. Reset returns the code to zero.

The counter moduli are parameters. A build with small moduli gives the same behaviour with short periods.

Top module: `decade_tick_gen`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `tick` is 0 and `rate_q` is 000.
- R2: Rate code k (1 to 7) gives a tick every FIRST_MOD × STAGE_MOD^(k−1) reference clocks. With the defaults (100 and 10, 10 MHz reference) this is 001 = 10 us, 010 = 100 us, 011 = 1 ms, 100 = 10 ms, 101 = 100 ms, 110 = 1 s, 111 = 10 s.
- R3: Each tick is high for exactly one reference clock.
- R4: While `rate_q` is 000, `tick` stays 0.
- R5: A load clears the whole counter chain. With the load sampled at clock edge E, the first tick is high in the cycle after edge E + P, where P is the period of the new code. This holds even when the code is the same as before and the load comes in the middle of a period.
- R6: A load sampled at the same edge at which a tick would have been registered suppresses that tick. The new period then counts from that edge.
- R7: `rate_q` shows the code captured by the last load from the cycle after that load. Changes on `rate_in` without `load` have no effect on `rate_q` or on the tick timing.
- R8: Reset applied during operation stops the ticks and returns `rate_q` to 000.
- R9: Loading code 000 produces no tick in any cycle after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (10 MHz in the default build) |
| rst | input | 1 | Synchronous active-high master reset |
| load | input | 1 | Strobe: capture `rate_in` and restart the counter chain |
| rate_in | input | CODE_W | Rate code applied on `load` |
| tick | output | 1 | One-clock tick pulse at the selected period |
| rate_q | output | CODE_W | Currently applied rate code |

## Verification
The case that needs care is a load sampled at the same edge at which the selected counter reaches its terminal count. In that cycle the restart and the tick request compete. The bench sets this up by timing a load on the fastest rate so that it lands exactly one period after a tick. It then checks that no tick appears after that edge, and that the next tick comes one full period of the newly loaded code later, counted from the load edge.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   localparam int unsigned DTG_CODE_W = 3;
   localparam int unsigned DTG_GAP_W  = 48;

   typedef logic [DTG_CODE_W-1:0] rate_code_t;
   typedef logic [DTG_GAP_W-1:0]  gap_t;

   // Tick period in reference clocks for a rate code; zero means no ticks.
   function automatic gap_t period_of(input int unsigned first_mod,
                                      input int unsigned stage_mod,
                                      input rate_code_t  code);
      gap_t p;
      if (code == '0) return '0;
      p = gap_t'(first_mod);
      for (int i = 1; i < int'(code); i++) p = p * gap_t'(stage_mod);
      return p;
   endfunction

endpackage

// File: rtl/dtg_stage.sv
module dtg_stage #(
   parameter int unsigned MOD = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic carry
);
   localparam int unsigned CW = (MOD > 1) ? $clog2(MOD) : 1;

   logic [CW-1:0] cnt_q;
   logic          at_top;

   generate
      if (MOD < 2) begin : g_bad_mod
         $error("dtg_stage: MOD must be at least 2");
      end
   endgenerate

   assign at_top = (cnt_q == CW'(MOD - 1));
   assign carry  = en & at_top;

   always_ff @(posedge clk) begin
      if (rst || clr)   cnt_q <= '0;
      else if (en)      cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end

   // R2: counter never leaves its modulus
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
      int'(cnt_q) < MOD);

   // R2: terminal count wraps back to zero when enabled
   p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (en && !clr && at_top) |=> (cnt_q == '0));

   // R5: a restart leaves the stage at zero
   p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/dtg_rate_reg.sv
module dtg_rate_reg #(
   parameter int unsigned CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CODE_W-1:0] rate_in,
   output logic [CODE_W-1:0] rate_q
);
   always_ff @(posedge clk) begin
      if (rst)       rate_q <= '0;
      else if (load) rate_q <= rate_in;
   end

   // R7: code changes only through a load
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(rate_q));

   // R7: a load captures the presented code
   p_capture_r7: assert property (@(posedge clk) disable iff (rst)
      load |=> (rate_q == $past(rate_in)));

endmodule

// File: rtl/dtg_tick_sel.sv
module dtg_tick_sel #(
   parameter int unsigned CODE_W  = 3,
   parameter int unsigned NUM_SRC = 7
) (
   input  logic [NUM_SRC-1:0] src,
   input  logic [CODE_W-1:0]  code,
   output logic               hit
);
   logic [NUM_SRC-1:0] match;

   generate
      if (NUM_SRC != (1 << CODE_W) - 1) begin : g_bad_src
         $error("dtg_tick_sel: NUM_SRC must equal 2**CODE_W - 1");
      end
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
         assign match[g] = src[g] & (code == CODE_W'(g + 1));
      end
   endgenerate

   assign hit = |match;

endmodule

// File: rtl/decade_tick_gen.sv
module decade_tick_gen #(
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned FIRST_MOD = 100,
   parameter int unsigned STAGE_MOD = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CODE_W-1:0] rate_in,
   output logic              tick,
   output logic [CODE_W-1:0] rate_q
);
   import dtg_pkg::*;

   localparam int unsigned NUM_STAGES = (1 << CODE_W) - 1;

   logic [NUM_STAGES-1:0] stage_en;
   logic [NUM_STAGES-1:0] stage_carry;
   logic                  tick_hit;

   generate
      if (CODE_W != DTG_CODE_W) begin : g_bad_width
         $error("decade_tick_gen: CODE_W must match the package code width");
      end
      if (FIRST_MOD < 2 || STAGE_MOD < 2) begin : g_bad_mods
         $error("decade_tick_gen: stage moduli must be at least 2");
      end

      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chain
         if (s == 0) begin : g_head
            assign stage_en[s] = 1'b1;
            dtg_stage #(.MOD(FIRST_MOD)) u_stage (
               .clk(clk), .rst(rst), .clr(load),
               .en(stage_en[s]), .carry(stage_carry[s]));
         end else begin : g_tail
            assign stage_en[s] = stage_carry[s-1];
            dtg_stage #(.MOD(STAGE_MOD)) u_stage (
               .clk(clk), .rst(rst), .clr(load),
               .en(stage_en[s]), .carry(stage_carry[s]));
         end
      end
   endgenerate

   dtg_rate_reg #(.CODE_W(CODE_W)) u_rate (
      .clk(clk), .rst(rst), .load(load),
      .rate_in(rate_in), .rate_q(rate_q));

   dtg_tick_sel #(.CODE_W(CODE_W), .NUM_SRC(NUM_STAGES)) u_sel (
      .src(stage_carry), .code(rate_q), .hit(tick_hit));

   always_ff @(posedge clk) begin
      if (rst || load) tick <= 1'b0;
      else             tick <= tick_hit;
   end

   // Checker counter: clocks since the last load or tick.
   gap_t gap_q;
   always_ff @(posedge clk) begin
      if (rst || load) gap_q <= '0;
      else if (tick)   gap_q <= gap_t'(1);
      else             gap_q <= gap_q + 1'b1;
   end

   // R2, R5: every tick lands exactly one period after the last tick or load
   p_period_r2: assert property (@(posedge clk) disable iff (rst)
      tick |-> (gap_q == period_of(FIRST_MOD, STAGE_MOD, rate_q)));

   // R3: a tick lasts one clock
   p_single_r3: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R4: code zero is silent
   p_silent_r4: assert property (@(posedge clk) disable iff (rst)
      (rate_q == '0) |-> !tick);

   // R6: a load suppresses the tick of that edge
   p_load_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      load |=> !tick);

endmodule

// File: tb/sim_decade_tick_gen.sv
module sim_decade_tick_gen;

   localparam int unsigned FM = 4;
   localparam int unsigned SM = 3;

   // Stimulus code and expected period (FM * SM**(code-1)) per row.
   localparam int VEC_CODE [8] = '{3, 1, 7, 2, 5, 4, 6, 1};
   localparam int VEC_EXP  [8] = '{36, 4, 2916, 12, 324, 108, 972, 4};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic [2:0] rate_in = 3'd0;
   logic       tick;
   logic [2:0] rate_q;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   decade_tick_gen #(.CODE_W(3), .FIRST_MOD(FM), .STAGE_MOD(SM)) u0 (
      .clk(clk), .rst(rst), .load(load), .rate_in(rate_in),
      .tick(tick), .rate_q(rate_q));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic load_code(input logic [2:0] c);
      rate_in = c; load = 1'b1;
      step();
      load = 1'b0;
   endtask

   task automatic wait_tick(input int maxc, output int cyc);
      cyc = 0;
      do begin step(); cyc++; end while (!tick && cyc < maxc);
   endtask

   task automatic count_ticks(input int ncyc, output int nt);
      nt = 0;
      for (int i = 0; i < ncyc; i++) begin step(); if (tick) nt++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int c;
      int nt;
      #1;
      repeat (3) step();
      chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
      chk(rate_q == 3'd0, "R1 rate in reset", int'(rate_q), 0);
      rst = 1'b0;
      step();
      chk(tick == 1'b0 && rate_q == 3'd0, "R1 after release", int'(rate_q), 0);
      count_ticks(200, nt);
      chk(nt == 0, "R4 idle code zero", nt, 0);

      // Vector table: each code, first tick, next gap, pulse width
      for (int v = 0; v < 8; v++) begin
         load_code(3'(VEC_CODE[v]));
         chk(rate_q == 3'(VEC_CODE[v]), "R7 rate readback", int'(rate_q), VEC_CODE[v]);
         wait_tick(3 * VEC_EXP[v] + 8, c);
         chk(c == VEC_EXP[v], "R5 first tick after load", c, VEC_EXP[v]);
         wait_tick(3 * VEC_EXP[v] + 8, c);
         chk(c == VEC_EXP[v], "R2 tick period", c, VEC_EXP[v]);
         step();
         chk(tick == 1'b0, "R3 single clock tick", int'(tick), 0);
      end

      // R5: same-code reload mid-period restarts the chain
      load_code(3'd3);
      repeat (10) step();
      load_code(3'd3);
      wait_tick(200, c);
      chk(c == 36, "R5 reload mid-period", c, 36);

      // R6: load on the terminal-count edge of code 1
      load_code(3'd1);
      wait_tick(20, c);
      chk(c == 4, "R6 setup tick", c, 4);
      repeat (3) step();
      load_code(3'd2);
      chk(tick == 1'b0, "R6 tick suppressed by load", int'(tick), 0);
      wait_tick(60, c);
      chk(c == 12, "R6 new period from load edge", c, 12);

      // R7: rate_in changes without load are ignored
      wait_tick(60, c);
      rate_in = 3'd5;
      wait_tick(60, c);
      chk(c == 12, "R7 period unchanged without load", c, 12);
      chk(rate_q == 3'd2, "R7 rate held without load", int'(rate_q), 2);

      // R9: loading code zero silences ticks
      load_code(3'd1);
      wait_tick(20, c);
      load_code(3'd0);
      chk(rate_q == 3'd0, "R9 rate after zero load", int'(rate_q), 0);
      count_ticks(50, nt);
      chk(nt == 0, "R9 no ticks after zero load", nt, 0);

      // R8: reset during operation
      load_code(3'd1);
      wait_tick(20, c);
      repeat (2) step();
      rst = 1'b1;
      step();
      rst = 1'b0;
      chk(rate_q == 3'd0, "R8 rate cleared by reset", int'(rate_q), 0);
      count_ticks(40, nt);
      chk(nt == 0, "R8 no ticks after reset", nt, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule